// File: doc/BRIEF.md
# External Interrupt Input Conditioner

This block sits between three external interrupt pins and the interrupt controller of an 8-bit controller. One pin carries a non-maskable request. The other two carry maskable requests. Each pin passes through a two-stage synchroniser and then through a width filter. The filter rejects any pulse shorter than the minimum width for its pin class. After the filter, the detection rule for that pin is applied.

The non-maskable pin always reacts to a falling edge. The first maskable pin reacts either to a rising edge or to a high level, chosen by a mode input. The second maskable pin always reacts to a rising edge. It belongs to a slower class whose filter looks at the pin only once every few clocks.

An edge-detected request is held in a flag until that source's own clear input is pulsed. In level mode the request output simply follows the filtered pin state. Priority, vectoring and acknowledge sequencing belong to the interrupt controller.

Top module: `ext_irq_cond`

## Requirements
- R1: After reset, all three request outputs are low. With `int0_level_mode_i` low (its reset value in the mode register), the first maskable pin is in rising-edge mode.
- R2: An accepted falling edge on `nmi_pin_i` (idle level high) sets `nmi_req_o`. An accepted rising edge alone does not set it.
- R3: With `int0_level_mode_i` = 0, an accepted rising edge on `int0_pin_i` (idle low) sets `int0_req_o`. A falling edge alone does not set it.
- R4: With `int0_level_mode_i` = 1, `int0_req_o` equals the filtered level of `int0_pin_i`, is never latched, and `int0_clr_i` has no effect on it.
- R5: An accepted rising edge on `int1_pin_i` (idle low) sets `int1_req_o`. A falling edge alone does not set it.
- R6: On `nmi_pin_i` and `int0_pin_i`, a new level held for FAST_SAMPLES (4) clocks is accepted. A level held for fewer clocks is ignored.
- R7: `int1_pin_i` is sampled once every SLOW_DIV (4) clocks and needs SLOW_SAMPLES (3) consecutive equal samples. A pulse of at most (SLOW_SAMPLES-1)*SLOW_DIV = 8 clocks is never accepted. A pulse of at least SLOW_SAMPLES*SLOW_DIV = 12 clocks is always accepted.
- R8: For the fast class, a pin change first sampled at clock edge k makes a latched request visible after edge k+6 (the 7th edge counting k). It makes a level-mode request visible after edge k+5.
- R9: A latched flag stays set until its own clear input is high at a clock edge. Clear inputs of the other sources, including both maskable clears for the non-maskable flag, leave it unchanged.
- R10: When an edge is detected in the same cycle as that source's clear, the flag is set.
- R11: While `int0_level_mode_i` is 1, the first maskable source's latched flag is discarded, so it reads low on return to edge mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nmi_pin_i | input | 1 | Non-maskable request pin, asynchronous |
| int0_pin_i | input | 1 | First maskable request pin, asynchronous |
| int1_pin_i | input | 1 | Second maskable request pin, slow class |
| int0_level_mode_i | input | 1 | 1: high-level mode, 0: rising-edge mode for the first maskable pin |
| nmi_clr_i | input | 1 | Clears the non-maskable flag |
| int0_clr_i | input | 1 | Clears the first maskable flag |
| int1_clr_i | input | 1 | Clears the second maskable flag |
| nmi_req_o | output | 1 | Non-maskable request |
| int0_req_o | output | 1 | First maskable request |
| int1_req_o | output | 1 | Second maskable request |

## Verification
Fast-class results are due at exact edges: a latched flag appears at the 7th rising edge after the pin change, and a level-mode output at the 6th. The bench probes both one edge early, expecting the old value, and on the due edge. For the slow class, acceptance depends on the prescaler phase, so the bench sweeps the pulse start over all four phases. Each pulse length is then judged only after a settle time longer than the worst-case latency. Clears and set-versus-clear collisions are driven at the negative edge before the edge on which they are meant to act, and their result is read at the negative edge that follows.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int unsigned NUM_SRC  = 3;
  localparam int unsigned SRC_NMI  = 0;
  localparam int unsigned SRC_INT0 = 1;
  localparam int unsigned SRC_INT1 = 2;

  typedef enum logic [1:0] {
    TRIG_FALL = 2'd0,
    TRIG_RISE = 2'd1,
    TRIG_PROG = 2'd2
  } trig_e;
endpackage

// File: rtl/irq_sync2.sv
module irq_sync2 #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/irq_width_filter.sv
module irq_width_filter #(
  parameter int unsigned SAMPLES = 4,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic d_i,
  output logic lvl_o
);
  localparam int unsigned CW = (SAMPLES > 2) ? $clog2(SAMPLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(SAMPLES - 1);

  logic          lvl_q;
  logic [CW-1:0] cnt_q;

  // level moves only after SAMPLES consecutive enabled samples disagree
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= RST_VAL;
      cnt_q <= '0;
    end else if (en_i) begin
      if (d_i == lvl_q) begin
        cnt_q <= '0;
      end else if (cnt_q == LAST) begin
        lvl_q <= d_i;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign lvl_o = lvl_q;

  p_change_on_sample_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_q != $past(lvl_q)) |-> $past(en_i));
  p_follows_input_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_q != $past(lvl_q)) |-> (lvl_q == $past(d_i)));
  p_count_bounded_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/irq_flag.sv
module irq_flag
  import ext_irq_pkg::*;
#(
  parameter trig_e TRIG = TRIG_RISE,
  parameter logic  IDLE = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic clr_i,
  input  logic hold_off_i,
  output logic flag_o
);
  logic lvl_q, flag_q, hit;

  generate
    if (TRIG == TRIG_FALL) begin : g_fall
      assign hit = lvl_q & ~lvl_i;
    end else begin : g_rise
      assign hit = ~lvl_q & lvl_i;
    end
  endgenerate

  // set beats clear; level mode discards the latched edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= IDLE;
      flag_q <= 1'b0;
    end else begin
      lvl_q <= lvl_i;
      if (hold_off_i)  flag_q <= 1'b0;
      else if (hit)    flag_q <= 1'b1;
      else if (clr_i)  flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;

  p_set_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && !hold_off_i) |=> flag_q);
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hit && !clr_i && !hold_off_i) |=> $stable(flag_q));
  p_discard_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_off_i |=> !flag_q);
endmodule

// File: rtl/ext_irq_cond.sv
module ext_irq_cond
  import ext_irq_pkg::*;
#(
  parameter int unsigned FAST_SAMPLES = 4,
  parameter int unsigned SLOW_SAMPLES = 3,
  parameter int unsigned SLOW_DIV     = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nmi_pin_i,
  input  logic int0_pin_i,
  input  logic int1_pin_i,
  input  logic int0_level_mode_i,
  input  logic nmi_clr_i,
  input  logic int0_clr_i,
  input  logic int1_clr_i,
  output logic nmi_req_o,
  output logic int0_req_o,
  output logic int1_req_o
);
  localparam int unsigned DW = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(SLOW_DIV - 1);

  logic [NUM_SRC-1:0] pin_w, clr_w, sync_w, lvl_w, flag_w;
  logic [DW-1:0]      div_q;
  logic               slow_tick;

  assign pin_w = {int1_pin_i, int0_pin_i, nmi_pin_i};
  assign clr_w = {int1_clr_i, int0_clr_i, nmi_clr_i};

  assign slow_tick = (div_q == DIV_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        div_q <= '0;
    else if (slow_tick) div_q <= '0;
    else                div_q <= div_q + 1'b1;
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    localparam logic        IDLE = (g == SRC_NMI);
    localparam int unsigned SMP  = (g == SRC_INT1) ? SLOW_SAMPLES : FAST_SAMPLES;
    localparam trig_e       TK   = (g == SRC_NMI)  ? TRIG_FALL :
                                   (g == SRC_INT0) ? TRIG_PROG : TRIG_RISE;
    logic en, hold;

    assign en   = (g == SRC_INT1) ? slow_tick : 1'b1;
    assign hold = (g == SRC_INT0) ? int0_level_mode_i : 1'b0;

    irq_sync2 #(.RST_VAL(IDLE)) i_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (pin_w[g]),
      .q_o   (sync_w[g])
    );

    irq_width_filter #(.SAMPLES(SMP), .RST_VAL(IDLE)) i_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (en),
      .d_i   (sync_w[g]),
      .lvl_o (lvl_w[g])
    );

    irq_flag #(.TRIG(TK), .IDLE(IDLE)) i_flag (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .lvl_i     (lvl_w[g]),
      .clr_i     (clr_w[g]),
      .hold_off_i(hold),
      .flag_o    (flag_w[g])
    );
  end

  assign nmi_req_o  = flag_w[SRC_NMI];
  assign int0_req_o = int0_level_mode_i ? lvl_w[SRC_INT0] : flag_w[SRC_INT0];
  assign int1_req_o = flag_w[SRC_INT1];

  p_nmi_own_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(nmi_req_o) |-> $past(nmi_clr_i));
  p_nmi_on_fall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nmi_req_o) |-> $past(!lvl_w[SRC_NMI]));
  p_int1_on_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(int1_req_o) |-> $past(lvl_w[SRC_INT1]));
  p_slow_tick_sparse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slow_tick |=> !slow_tick);
endmodule

// File: tb/test_ext_irq_cond.sv
module test_ext_irq_cond;
  localparam int CLK_PERIOD = 10;
  localparam int FAST_W = 4;
  localparam int SLOW_S = 3;
  localparam int SLOW_D = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nmi = 1'b1, int0 = 1'b0, int1 = 1'b0, mode = 1'b0;
  logic clr_n = 1'b0, clr_0 = 1'b0, clr_1 = 1'b0;
  logic req_n, req_0, req_1;
  int   n_cmp = 0, n_bad = 0;
  bit   done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_irq_cond #(.FAST_SAMPLES(FAST_W), .SLOW_SAMPLES(SLOW_S), .SLOW_DIV(SLOW_D)) i_ext_irq_cond (
    .clk_i(clk), .rst_ni(rst_n),
    .nmi_pin_i(nmi), .int0_pin_i(int0), .int1_pin_i(int1),
    .int0_level_mode_i(mode),
    .nmi_clr_i(clr_n), .int0_clr_i(clr_0), .int1_clr_i(clr_1),
    .nmi_req_o(req_n), .int0_req_o(req_0), .int1_req_o(req_1)
  );

  task automatic chk(string tag, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_pin(int which, logic v);
    case (which)
      0: nmi = v;
      1: int0 = v;
      default: int1 = v;
    endcase
  endtask

  task automatic clear(int which);
    case (which)
      0: clr_n = 1'b1;
      1: clr_0 = 1'b1;
      default: clr_1 = 1'b1;
    endcase
    step(1);
    clr_n = 1'b0; clr_0 = 1'b0; clr_1 = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(2);
    // R1 reset state
    chk("R1 nmi_req after reset", req_n, 1'b0);
    chk("R1 int0_req after reset", req_0, 1'b0);
    chk("R1 int1_req after reset", req_1, 1'b0);

    // R8 latency, edge mode (NMI falling)
    nmi = 1'b0;
    step(6);
    chk("R8 nmi flag one edge early", req_n, 1'b0);
    step(1);
    chk("R8 nmi flag due edge", req_n, 1'b1);
    // R2: rise alone does not set after clear
    clear(0);
    chk("R9 nmi cleared", req_n, 1'b0);
    nmi = 1'b1;
    step(14);
    chk("R2 nmi rising edge ignored", req_n, 1'b0);

    // R8 latency, edge mode INT0 rising
    int0 = 1'b1;
    step(6);
    chk("R8 int0 flag one edge early", req_0, 1'b0);
    step(1);
    chk("R3 int0 rising edge latched", req_0, 1'b1);
    clear(1);
    chk("R9 int0 cleared", req_0, 1'b0);
    int0 = 1'b0;
    step(14);
    chk("R3 int0 falling edge ignored", req_0, 1'b0);

    // R6 width sweep on fast class
    for (int src = 0; src < 2; src++) begin
      for (int len = 1; len <= 7; len++) begin
        set_pin(src, (src == 0) ? 1'b0 : 1'b1);
        step(len);
        set_pin(src, (src == 0) ? 1'b1 : 1'b0);
        step(14);
        chk($sformatf("R6 src%0d pulse len %0d", src, len),
            (src == 0) ? req_n : req_0, (len >= FAST_W) ? 1'b1 : 1'b0);
        clear(src);
      end
    end

    // R7 slow class sweep over phase and length
    for (int off = 0; off < SLOW_D; off++) begin
      for (int len = 4; len <= 16; len += 4) begin
        step(off);
        int1 = 1'b1;
        step(len);
        int1 = 1'b0;
        step(30);
        chk($sformatf("R7 int1 phase %0d len %0d", off, len), req_1,
            (len >= SLOW_S*SLOW_D) ? 1'b1 : 1'b0);
        clear(2);
      end
    end

    // R5 int1 rising latched, falling ignored
    int1 = 1'b1;
    step(30);
    chk("R5 int1 rising edge latched", req_1, 1'b1);
    clear(2);
    int1 = 1'b0;
    step(30);
    chk("R5 int1 falling edge ignored", req_1, 1'b0);

    // R4 level mode
    mode = 1'b1;
    step(2);
    int0 = 1'b1;
    step(5);
    chk("R8 int0 level one edge early", req_0, 1'b0);
    step(1);
    chk("R4 int0 level follows pin high", req_0, 1'b1);
    clear(1);
    chk("R4 int0 clear ignored in level mode", req_0, 1'b1);
    int0 = 1'b0;
    step(10);
    chk("R4 int0 level follows pin low", req_0, 1'b0);
    int0 = 1'b1;
    step(3);
    int0 = 1'b0;
    step(10);
    chk("R4 short level pulse rejected", req_0, 1'b0);

    // R11 latched edge discarded by level mode
    mode = 1'b0;
    step(2);
    int0 = 1'b1;
    step(8);
    int0 = 1'b0;
    step(10);
    chk("R11 int0 latched before level mode", req_0, 1'b1);
    mode = 1'b1;
    step(2);
    mode = 1'b0;
    step(1);
    chk("R11 int0 flag discarded", req_0, 1'b0);

    // R9 independence of clears
    nmi = 1'b0; int0 = 1'b1; int1 = 1'b1;
    step(30);
    nmi = 1'b1; int0 = 1'b0; int1 = 1'b0;
    step(30);
    chk("R9 nmi set", req_n, 1'b1);
    chk("R9 int0 set", req_0, 1'b1);
    chk("R9 int1 set", req_1, 1'b1);
    clear(1);
    clear(2);
    chk("R9 nmi kept by other clears", req_n, 1'b1);
    chk("R9 int0 cleared by own clear", req_0, 1'b0);
    chk("R9 int1 cleared by own clear", req_1, 1'b0);
    step(5);
    chk("R9 nmi still held", req_n, 1'b1);
    clear(0);
    chk("R9 nmi cleared by own clear", req_n, 1'b0);

    // R10 set wins over simultaneous clear
    nmi = 1'b0;
    step(6);
    clr_n = 1'b1;
    step(1);
    clr_n = 1'b0;
    chk("R10 nmi set beats clear", req_n, 1'b1);
    clear(0);
    nmi = 1'b1;
    step(10);
    int0 = 1'b1;
    step(6);
    clr_0 = 1'b1;
    step(1);
    clr_0 = 1'b0;
    chk("R10 int0 set beats clear", req_0, 1'b1);
    int0 = 1'b0;
    step(10);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule